// File: doc/BRIEF.md
# Dual Step-Up Converter Digital Mode Controller

This block holds the digital control state for two step-up converters and turns it into switching decisions. Each converter has its own configuration field, written through a single register port: a software enable, a mode bit that picks fixed-frequency pulse-width operation (PWM) or load-driven pulse-frequency operation (PFM), a rectifier-disable bit and a four-bit switching-frequency code. A converter runs only while the shared enable pin is high and its own enable bit is set. From that state the block drives a gate enable and a rectifier-on signal for each converter. It also selects the clock source for the PWM period counters and raises a request for the crystal clock.

In PWM mode a period counter advances on ticks of the selected source. That source is the crystal tick, or the codec tick whenever the codec is enabled. The frequency code sets the period length and is taken up only when a period wraps. In PFM mode the gate fires a one-cycle pulse when the "output low" input is asserted, and a fixed minimum off-time follows. The rectifier follows two comparator inputs: it turns on when the switch node rises above the output and off when the inductor current falls below its threshold. A set disable bit holds it off. A converter that is not running has its rectifier forced on, and this takes priority over the disable bit.

Each converter has one state machine with five states. S_OFF means not running. S_PWM is pulse-width switching. S_PFM_WAIT waits for "output low". S_PFM_PULSE is the single gate cycle. S_PFM_REST is the minimum off-time. The transitions are:
- Any state goes to S_OFF when the converter is not running.
- S_OFF goes to S_PWM or S_PFM_WAIT according to the mode bit.
- S_PWM goes to S_PFM_WAIT when PFM is selected.
- S_PFM_WAIT goes to S_PWM when PWM is selected, or to S_PFM_PULSE when "output low" is seen.
- S_PFM_PULSE always goes to S_PFM_REST.
- S_PFM_REST goes to S_PFM_WAIT or S_PWM once the off-time has run out.

Top module: `dcdc_mode_ctrl`

## Requirements
- R1: A converter is running only while `en_pin` is high and its enable bit is set. While it is not running its gate is low, and its state machine is in S_OFF one clock later.
- R2: Converter k owns `cfg_wdata[8k+7:8k]`. Bit 0 of the field is the rectifier disable, bit 1 the enable, bit 2 the mode (0 = PWM, 1 = PFM) and bits 7:4 the frequency code. A write with `cfg_we` high takes effect at the next clock edge. After reset both converters are enabled in PWM mode, with code 0 and the rectifier disable clear.
- R3: `clk_sel` equals `codec_en`. The period counters count `codec_tick` when it is 1 and `xtal_tick` when it is 0.
- R4: `xtal_req` is high exactly when `ext_xtal_need` is high or at least one running converter is in PWM mode.
- R5: In S_PWM the period is 4 + code ticks. The gate is high while the tick count within the period is below half the period, rounded down. A new code is applied only when the count wraps to zero.
- R6: When a converter is running and its disable bit is clear, its rectifier turns on after a clock with `sw_above` high. It turns off after a clock with `i_below` high, and `i_below` wins if both are high.
- R7: A converter that is not running drives its `rect_on` high, whatever its disable bit holds.
- R8: When a running converter has its disable bit set, its `rect_on` is low, whatever the comparator inputs are.
- R9: In PFM mode a clock in S_PFM_WAIT with `out_low` high gives exactly one gate-high cycle (S_PFM_PULSE). Three gate-low cycles follow (S_PFM_REST) before the next pulse can start. With `out_low` held high the gate is therefore high one cycle in five.
- R10: A mode change moves a running converter between S_PWM and S_PFM_WAIT on the next clock. In S_PFM_WAIT the gate stays low while `out_low` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_pin | input | 1 | Shared converter enable pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word, one 8-bit field per converter |
| codec_en | input | 1 | Codec enabled; selects the codec tick as PWM source |
| xtal_tick | input | 1 | One-cycle tick derived from the crystal clock |
| codec_tick | input | 1 | One-cycle tick derived from the codec clock |
| ext_xtal_need | input | 1 | Another block needs the crystal clock |
| out_low | input | 2 | Per converter: output below target (PFM trigger) |
| sw_above | input | 2 | Per converter: switch node above output comparator |
| i_below | input | 2 | Per converter: inductor current below threshold comparator |
| gate | output | 2 | Per converter gate enable |
| rect_on | output | 2 | Per converter synchronous rectifier on |
| clk_sel | output | 1 | PWM clock source: 1 = codec, 0 = crystal |
| xtal_req | output | 1 | Crystal clock request |

## Verification
The assertions assume that the tick inputs and the comparator inputs are already synchronous to `clk` and last a single cycle or longer. They also assume that the minimum off-time parameter is at least one. The bench drives every input one time unit after the rising edge, so each value holds for a whole cycle. It produces ticks as plain clock-wide levels. The comparator inputs may change on any cycle, including both at once, which exercises the priority of `i_below`.

// File: rtl/dcdc_pkg.sv
package dcdc_pkg;
    localparam int FIELD_W     = 8;
    localparam int FREQ_CODE_W = 4;
    localparam int BIT_RDIS    = 0;
    localparam int BIT_EN      = 1;
    localparam int BIT_PFM     = 2;
    localparam int CODE_LSB    = 4;

    typedef enum logic [2:0] {
        S_OFF,
        S_PWM,
        S_PFM_WAIT,
        S_PFM_PULSE,
        S_PFM_REST
    } conv_state_e;

    typedef struct packed {
        logic [FREQ_CODE_W-1:0] code;
        logic                   pfm;
        logic                   en;
        logic                   rect_dis;
    } conv_cfg_t;
endpackage

// File: rtl/dcdc_cfg_reg.sv
module dcdc_cfg_reg
    import dcdc_pkg::*;
#(
    parameter int N_CONV = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [N_CONV*FIELD_W-1:0]     wdata_i,
    output conv_cfg_t [N_CONV-1:0]        cfg_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CONV; i++) begin
                cfg_o[i] <= '{code: '0, pfm: 1'b0, en: 1'b1, rect_dis: 1'b0};
            end
        end else if (we_i) begin
            for (int i = 0; i < N_CONV; i++) begin
                cfg_o[i].rect_dis <= wdata_i[i*FIELD_W+BIT_RDIS];
                cfg_o[i].en       <= wdata_i[i*FIELD_W+BIT_EN];
                cfg_o[i].pfm      <= wdata_i[i*FIELD_W+BIT_PFM];
                cfg_o[i].code     <= wdata_i[i*FIELD_W+CODE_LSB +: FREQ_CODE_W];
            end
        end
    end

    for (genvar g = 0; g < N_CONV; g++) begin : g_chk
        p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            we_i |=> (cfg_o[g].pfm == $past(wdata_i[g*FIELD_W+BIT_PFM]))
                  && (cfg_o[g].code == $past(wdata_i[g*FIELD_W+CODE_LSB +: FREQ_CODE_W])))
            else $error("R2 configuration write did not land");
    end
endmodule

// File: rtl/dcdc_conv_ctrl.sv
module dcdc_conv_ctrl
    import dcdc_pkg::*;
#(
    parameter int DIV_BASE = 4,
    parameter int MIN_OFF  = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_en_i,
    input  conv_cfg_t cfg_i,
    input  logic      tick_i,
    input  logic      out_low_i,
    input  logic      sw_above_i,
    input  logic      i_below_i,
    output logic      gate_o,
    output logic      rect_on_o,
    output logic      pwm_req_o
);
    localparam int PER_W = $clog2(DIV_BASE + (1 << FREQ_CODE_W) + 1);
    localparam int OFF_W = $clog2(MIN_OFF + 1);
    localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(MIN_OFF);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(1);

    conv_state_e      state_q, state_d;
    logic [PER_W-1:0] cnt_q, period_q, period_new;
    logic [OFF_W-1:0] rest_q;
    logic             rect_q, active, pwm_hi;

    assign active     = pin_en_i & cfg_i.en;
    assign period_new = PER_W'(DIV_BASE) + PER_W'(cfg_i.code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:       state_d = cfg_i.pfm ? S_PFM_WAIT : S_PWM;
                S_PWM:       if (cfg_i.pfm) state_d = S_PFM_WAIT;
                S_PFM_WAIT: begin
                    if (!cfg_i.pfm)     state_d = S_PWM;
                    else if (out_low_i) state_d = S_PFM_PULSE;
                end
                S_PFM_PULSE: state_d = S_PFM_REST;
                S_PFM_REST:  if (rest_q == OFF_LAST) state_d = cfg_i.pfm ? S_PFM_WAIT : S_PWM;
                default:     state_d = S_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= PER_W'(DIV_BASE);
            rest_q   <= '0;
            rect_q   <= 1'b0;
        end else begin
            if (state_q == S_PWM) begin
                if (tick_i) begin
                    if (cnt_q == period_q - 1'b1) begin
                        cnt_q    <= '0;
                        period_q <= period_new;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else begin
                cnt_q    <= '0;
                period_q <= period_new;
            end
            if (state_q == S_PFM_PULSE)     rest_q <= OFF_LOAD;
            else if (state_q == S_PFM_REST) rest_q <= rest_q - 1'b1;
            if (!active || cfg_i.rect_dis || i_below_i) rect_q <= 1'b0;
            else if (sw_above_i)                        rect_q <= 1'b1;
        end
    end

    always_comb begin
        pwm_hi = cnt_q < (period_q >> 1);
        unique case (state_q)
            S_PWM:       gate_o = active & pwm_hi;
            S_PFM_PULSE: gate_o = active;
            default:     gate_o = 1'b0;
        endcase
        rect_on_o = ~active | (~cfg_i.rect_dis & rect_q);
        pwm_req_o = active & ~cfg_i.pfm;
    end

    p_pulse_then_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PFM_PULSE && active) |=> state_q == S_PFM_REST)
        else $error("R9 pulse not followed by off-time");
    p_no_gate_after_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PFM_PULSE) |=> !gate_o)
        else $error("R9 gate high right after pulse");
    p_period_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(period_q) && $past(state_q) == S_PWM) |-> cnt_q == '0)
        else $error("R5 period changed mid-period");
    p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PWM) |-> cnt_q < period_q)
        else $error("R5 count beyond period");
endmodule

// File: rtl/dcdc_mode_ctrl.sv
module dcdc_mode_ctrl
    import dcdc_pkg::*;
#(
    parameter int N_CONV   = 2,
    parameter int DIV_BASE = 4,
    parameter int MIN_OFF  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_pin,
    input  logic                      cfg_we,
    input  logic [N_CONV*FIELD_W-1:0] cfg_wdata,
    input  logic                      codec_en,
    input  logic                      xtal_tick,
    input  logic                      codec_tick,
    input  logic                      ext_xtal_need,
    input  logic [N_CONV-1:0]         out_low,
    input  logic [N_CONV-1:0]         sw_above,
    input  logic [N_CONV-1:0]         i_below,
    output logic [N_CONV-1:0]         gate,
    output logic [N_CONV-1:0]         rect_on,
    output logic                      clk_sel,
    output logic                      xtal_req
);
    conv_cfg_t [N_CONV-1:0] cfg;
    logic      [N_CONV-1:0] pwm_req;
    logic                   tick;

    assign clk_sel  = codec_en;
    assign tick     = codec_en ? codec_tick : xtal_tick;
    assign xtal_req = ext_xtal_need | (|pwm_req);

    dcdc_cfg_reg #(.N_CONV(N_CONV)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .wdata_i(cfg_wdata),
        .cfg_o  (cfg)
    );

    for (genvar g = 0; g < N_CONV; g++) begin : g_conv
        dcdc_conv_ctrl #(.DIV_BASE(DIV_BASE), .MIN_OFF(MIN_OFF)) u_conv (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_en_i  (en_pin),
            .cfg_i     (cfg[g]),
            .tick_i    (tick),
            .out_low_i (out_low[g]),
            .sw_above_i(sw_above[g]),
            .i_below_i (i_below[g]),
            .gate_o    (gate[g]),
            .rect_on_o (rect_on[g]),
            .pwm_req_o (pwm_req[g])
        );
    end
endmodule

// File: tb/dcdc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module dcdc_mode_ctrl_bench;
    localparam int MIN_OFF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_pin = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        codec_en = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        codec_tick = 1'b0;
    logic        ext_xtal_need = 1'b0;
    logic [1:0]  out_low = '0;
    logic [1:0]  sw_above = '0;
    logic [1:0]  i_below = '0;
    logic [1:0]  gate, rect_on;
    logic        clk_sel, xtal_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dcdc_mode_ctrl u_dcdc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .codec_en(codec_en), .xtal_tick(xtal_tick), .codec_tick(codec_tick),
        .ext_xtal_need(ext_xtal_need), .out_low(out_low), .sw_above(sw_above),
        .i_below(i_below), .gate(gate), .rect_on(rect_on), .clk_sel(clk_sel),
        .xtal_req(xtal_req)
    );

    // reference model: 0 off, 1 pwm, 2 wait, 3 pulse, 4 rest
    int m_st[2], m_cnt[2], m_per[2], m_rest[2], m_code[2];
    bit m_rq[2], m_en[2], m_pfm[2], m_dis[2];

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_per[i] = 4; m_rest[i] = 0; m_code[i] = 0;
            m_rq[i] = 0; m_en[i] = 1; m_pfm[i] = 0; m_dis[i] = 0;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit act, tk;
                int nst;
                act = en_pin && m_en[i];
                tk  = codec_en ? codec_tick : xtal_tick;
                if (m_st[i] == 1) begin
                    if (tk) begin
                        if (m_cnt[i] == m_per[i] - 1) begin
                            m_cnt[i] = 0; m_per[i] = 4 + m_code[i];
                        end else m_cnt[i] = m_cnt[i] + 1;
                    end
                end else begin
                    m_cnt[i] = 0; m_per[i] = 4 + m_code[i];
                end
                nst = m_st[i];
                if (!act) nst = 0;
                else if (m_st[i] == 0) nst = m_pfm[i] ? 2 : 1;
                else if (m_st[i] == 1) begin if (m_pfm[i]) nst = 2; end
                else if (m_st[i] == 2) begin
                    if (!m_pfm[i]) nst = 1; else if (out_low[i]) nst = 3;
                end
                else if (m_st[i] == 3) nst = 4;
                else if (m_rest[i] == 1) nst = m_pfm[i] ? 2 : 1;
                if (m_st[i] == 3) m_rest[i] = MIN_OFF;
                else if (m_st[i] == 4) m_rest[i] = m_rest[i] - 1;
                m_st[i] = nst;
                if (!act || m_dis[i] || i_below[i]) m_rq[i] = 0;
                else if (sw_above[i]) m_rq[i] = 1;
            end
            if (cfg_we) begin
                for (int i = 0; i < 2; i++) begin
                    m_dis[i]  = cfg_wdata[8*i];
                    m_en[i]   = cfg_wdata[8*i+1];
                    m_pfm[i]  = cfg_wdata[8*i+2];
                    m_code[i] = int'(cfg_wdata[8*i+4 +: 4]);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any_pwm;
            any_pwm = 0;
            for (int i = 0; i < 2; i++) begin
                bit act, eg, er;
                act = en_pin && m_en[i];
                eg  = act && ((m_st[i] == 1 && m_cnt[i] < m_per[i] / 2) || m_st[i] == 3);
                er  = !act || (!m_dis[i] && m_rq[i]);
                if (act && !m_pfm[i]) any_pwm = 1;
                chk(gate[i], eg, "R1 R5 R9 R10 gate model");
                chk(rect_on[i], er, "R6 R7 R8 rect_on model");
            end
            chk(xtal_req, ext_xtal_need || any_pwm, "R4 xtal_req model");
            chk(clk_sel, codec_en, "R3 clk_sel model");
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_wdata = d; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic count_gate(input int idx, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate[idx]) hi++;
        end
        step(1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        int hi;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R2: defaults give two running PWM converters
        chk(xtal_req, 1'b1, "R2 reset default PWM requests crystal");
        chk(clk_sel, 1'b0, "R2 R3 reset clock source crystal");

        // R5: code 2 -> period 6, half high
        xtal_tick = 1'b1;
        wr(16'h5222);
        step(20);
        count_gate(0, 24, hi);
        checks++;
        if (hi != 12) begin errors++; $display("FAIL R5 gate highs actual=%0d expected=12", hi); end

        // R3: codec source
        codec_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            codec_tick = k[0];
            xtal_tick  = 1'($urandom_range(0, 1));
            step(1);
        end
        chk(clk_sel, 1'b1, "R3 codec source selected");
        codec_en = 1'b0; xtal_tick = 1'b1;

        // R10: switch conv0 to PFM, no trigger -> gate low
        wr(16'h5226);
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk(gate[0], 1'b0, "R10 PFM wait keeps gate low");
        end
        // R9: held trigger gives one pulse in five
        out_low[0] = 1'b1;
        step(2);
        count_gate(0, 25, hi);
        checks++;
        if (hi != 5) begin errors++; $display("FAIL R9 pulse count actual=%0d expected=5", hi); end
        out_low[0] = 1'b0;

        // R4: both PFM -> no request; external need restores it
        wr(16'h5626);
        step(2);
        chk(xtal_req, 1'b0, "R4 both PFM drops request");
        ext_xtal_need = 1'b1;
        #0.5;
        chk(xtal_req, 1'b1, "R4 external need raises request");
        ext_xtal_need = 1'b0;

        // R8 and R6: rectifier disable and comparator control
        wr(16'h5627);
        sw_above[0] = 1'b1;
        step(3);
        chk(rect_on[0], 1'b0, "R8 disable holds rectifier off");
        wr(16'h5626);
        step(2);
        chk(rect_on[0], 1'b1, "R6 switch node above turns rectifier on");
        sw_above[0] = 1'b0; i_below[0] = 1'b1;
        step(1);
        chk(rect_on[0], 1'b0, "R6 current below turns rectifier off");
        i_below[0] = 1'b0;

        // R7 and R1: pin low forces rectifiers on, gates off
        en_pin = 1'b0;
        #0.5;
        chk(rect_on[0], 1'b1, "R7 pin low forces rectifier 0 on");
        chk(rect_on[1], 1'b1, "R7 pin low forces rectifier 1 on");
        chk(gate[1], 1'b0, "R1 pin low gate off");
        wr(16'h5627);
        step(1);
        chk(rect_on[0], 1'b1, "R7 forced on beats disable bit");
        en_pin = 1'b1;
        wr(16'h5624);
        step(1);
        chk(rect_on[0], 1'b1, "R1 R7 enable bit clear stops converter");
        chk(gate[0], 1'b0, "R1 enable bit clear gate off");

        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            en_pin        = ($urandom_range(0, 19) != 0);
            codec_en      = ($urandom_range(0, 99) < 50) ? codec_en : ~codec_en;
            xtal_tick     = 1'($urandom_range(0, 1));
            codec_tick    = 1'($urandom_range(0, 1));
            ext_xtal_need = ($urandom_range(0, 9) == 0);
            out_low       = 2'($urandom_range(0, 3));
            sw_above      = 2'($urandom_range(0, 3));
            i_below       = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            if ($urandom_range(0, 15) == 0) begin
                cfg_wdata = 16'($urandom) | 16'h0202;
                cfg_we = 1'b1;
            end else cfg_we = 1'b0;
            step(1);
        end
        cfg_we = 1'b0;
        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule